// File: doc/BRIEF.md
# Virtual-Channel Output Credit Tracker

This block keeps per-output-port state for a router that multiplexes several virtual channels (VCs) over one physical link. For each downstream VC it records whether a packet currently owns the VC and whether the downstream input buffer for that VC can take another flit. The switch and VC allocators read the exported flags and report back what they did. A head-flit grant claims a VC. Every flit sent on a VC uses one downstream buffer slot. The tail flit leaving the port releases the VC.

The downstream readiness comes from one of two schemes, chosen by a parameter. In counting mode, each VC has a counter that starts at the downstream buffer depth. It drops by one per flit sent and rises by one per credit pulse from downstream. The depth must be at least the credit round-trip time in cycles, or the link stalls. In on/off mode no counters exist, and readiness is the inverse of a per-VC stop level that downstream raises when its buffer is close to full. The same per-VC input pin carries the credit pulse in counting mode and the stop level in on/off mode.

Top module: `vc_credit_tracker`

## Requirements
- R1: After reset, every VC reports free (`vcFree` all ones), every VC reports space (`vcHasCredit` all ones), and each counting-mode counter equals `BufDepth`.
- R2: A head grant (`headGrantVld` with index `headGrantVc`) makes that VC's `vcFree` bit read 0 from the next cycle on.
- R3: A send with `flitSendTail`=1 makes that VC's `vcFree` bit read 1 from the next cycle on. A send with `flitSendTail`=0 leaves the VC owned.
- R4: In counting mode, each send lowers that VC's counter by one. After `BufDepth` sends with no credit pulses, `vcHasCredit` for that VC reads 0.
- R5: In counting mode, a 1 on `dsFeedback[v]` raises VC v's counter by one, so `vcHasCredit[v]` returns to 1.
- R6: In counting mode, a credit pulse and a send on the same VC in the same cycle leave its counter unchanged.
- R7: `vcSendReady[v]` is 1 exactly when VC v is owned (`vcFree[v]`=0) and `vcHasCredit[v]`=1.
- R8: In on/off mode (`OnOffMode`=1), `vcHasCredit[v]` is the inverse of the stop level on `dsFeedback[v]` in the same cycle, whatever the number of flits sent.
- R9: Grants, sends and feedback aimed at one VC do not change any other VC's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| headGrantVld | input | 1 | A head flit was granted a VC this cycle |
| headGrantVc | input | $clog2(NumVc) | Index of the granted VC |
| flitSendVld | input | 1 | A flit leaves on the link this cycle |
| flitSendVc | input | $clog2(NumVc) | VC of the departing flit |
| flitSendTail | input | 1 | The departing flit is a packet tail |
| dsFeedback | input | NumVc | Per-VC credit pulse (counting mode) or stop level (on/off mode) |
| vcFree | output | NumVc | VC is not owned by a packet |
| vcHasCredit | output | NumVc | Downstream buffer of the VC can accept a flit |
| vcSendReady | output | NumVc | VC is owned and has space |

## Verification
The checks assume the allocators behave. A head grant only targets a VC that reads free. A send only targets a VC that reads ready. A credit pulse only returns a slot that is outstanding, so the counter never goes past `BufDepth`. The bench's random traffic picks each grant, send and credit pulse against its own reference state, so it never leaves those bounds. The directed part drives one VC to zero credits and sends a credit pulse and a flit together on the same VC. It also raises a stop level while the on/off instance has flits in flight.

// File: rtl/vc_track_pkg.sv
package vc_track_pkg;
  // Per-VC strobes passed from control to datapath
  typedef struct packed {
    logic alloc;     // head grant claims the VC
    logic spend;     // one flit leaves on the VC
    logic tailFree;  // the departing flit ends the packet
    logic feedback;  // credit pulse or stop level from downstream
  } vcStrobe_t;
endpackage

// File: rtl/vc_track_ctrl.sv
module vc_track_ctrl
  import vc_track_pkg::*;
#(
  parameter int NumVc  = 4,
  parameter int VcIdxW = 2
) (
  input  logic                    headGrantVld,
  input  logic [VcIdxW-1:0]       headGrantVc,
  input  logic                    flitSendVld,
  input  logic [VcIdxW-1:0]       flitSendVc,
  input  logic                    flitSendTail,
  input  logic [NumVc-1:0]        dsFeedback,
  output vcStrobe_t [NumVc-1:0]   strobe
);
  for (genvar v = 0; v < NumVc; v++) begin : g_dec
    logic grantHit;
    logic sendHit;
    assign grantHit = headGrantVld && (headGrantVc == VcIdxW'(v));
    assign sendHit  = flitSendVld && (flitSendVc == VcIdxW'(v));
    assign strobe[v].alloc    = grantHit;
    assign strobe[v].spend    = sendHit;
    assign strobe[v].tailFree = sendHit && flitSendTail;
    assign strobe[v].feedback = dsFeedback[v];
  end
endmodule

// File: rtl/vc_track_dp.sv
module vc_track_dp
  import vc_track_pkg::*;
#(
  parameter int NumVc     = 4,
  parameter int BufDepth  = 4,
  parameter bit OnOffMode = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  vcStrobe_t [NumVc-1:0] strobe,
  output logic [NumVc-1:0]      vcBusy,
  output logic [NumVc-1:0]      vcHasCredit
);
  localparam int CntW = $clog2(BufDepth + 1);

  // Ownership: set on head grant, cleared when the tail departs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vcBusy <= '0;
    end else begin
      for (int v = 0; v < NumVc; v++) begin
        if (strobe[v].alloc) vcBusy[v] <= 1'b1;
        else if (strobe[v].tailFree) vcBusy[v] <= 1'b0;
      end
    end
  end

  if (OnOffMode == 1'b0) begin : g_credit
    for (genvar v = 0; v < NumVc; v++) begin : g_vc
      logic [CntW-1:0] creditCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          creditCnt <= CntW'(BufDepth);
        end else begin
          unique case ({strobe[v].feedback, strobe[v].spend})
            2'b10:   creditCnt <= creditCnt + 1'b1;
            2'b01:   creditCnt <= creditCnt - 1'b1;
            default: creditCnt <= creditCnt;
          endcase
        end
      end
      assign vcHasCredit[v] = (creditCnt != '0);
    end
  end else begin : g_onoff
    for (genvar v = 0; v < NumVc; v++) begin : g_vc
      assign vcHasCredit[v] = ~strobe[v].feedback;
    end
  end
endmodule

// File: rtl/vc_credit_tracker.sv
module vc_credit_tracker
  import vc_track_pkg::*;
#(
  parameter int NumVc     = 4,
  parameter int BufDepth  = 4,
  parameter bit OnOffMode = 1'b0,
  localparam int VcIdxW   = (NumVc > 1) ? $clog2(NumVc) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              headGrantVld,
  input  logic [VcIdxW-1:0] headGrantVc,
  input  logic              flitSendVld,
  input  logic [VcIdxW-1:0] flitSendVc,
  input  logic              flitSendTail,
  input  logic [NumVc-1:0]  dsFeedback,
  output logic [NumVc-1:0]  vcFree,
  output logic [NumVc-1:0]  vcHasCredit,
  output logic [NumVc-1:0]  vcSendReady
);
  vcStrobe_t [NumVc-1:0] strobe;
  logic [NumVc-1:0]      vcBusy;

  vc_track_ctrl #(.NumVc(NumVc), .VcIdxW(VcIdxW)) u_ctrl (
    .headGrantVld (headGrantVld),
    .headGrantVc  (headGrantVc),
    .flitSendVld  (flitSendVld),
    .flitSendVc   (flitSendVc),
    .flitSendTail (flitSendTail),
    .dsFeedback   (dsFeedback),
    .strobe       (strobe)
  );

  vc_track_dp #(.NumVc(NumVc), .BufDepth(BufDepth), .OnOffMode(OnOffMode)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .vcBusy      (vcBusy),
    .vcHasCredit (vcHasCredit)
  );

  assign vcFree      = ~vcBusy;
  assign vcSendReady = vcBusy & vcHasCredit;
endmodule

// File: rtl/vc_credit_tracker_chk.sv
module vc_credit_tracker_chk #(
  parameter int NumVc     = 4,
  parameter int BufDepth  = 4,
  parameter bit OnOffMode = 1'b0,
  parameter int VcIdxW    = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              headGrantVld,
  input logic [VcIdxW-1:0] headGrantVc,
  input logic              flitSendVld,
  input logic [VcIdxW-1:0] flitSendVc,
  input logic              flitSendTail,
  input logic [NumVc-1:0]  dsFeedback,
  input logic [NumVc-1:0]  vcFree,
  input logic [NumVc-1:0]  vcHasCredit,
  input logic [NumVc-1:0]  vcSendReady
);
  // R2
  grant_to_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    headGrantVld |-> vcFree[headGrantVc]);
  // R2
  grant_claims_chk: assert property (@(posedge clk) disable iff (!rstN)
    headGrantVld |=> !vcFree[$past(headGrantVc)]);
  // R3
  tail_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flitSendVld && flitSendTail) |=> vcFree[$past(flitSendVc)]);
  // R7
  send_when_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    flitSendVld |-> vcSendReady[flitSendVc]);

  if (OnOffMode == 1'b0) begin : g_credit
    localparam int CntW = $clog2(BufDepth + 1);
    for (genvar v = 0; v < NumVc; v++) begin : g_vc
      logic [CntW-1:0] shadowCnt;
      logic sendHere;
      assign sendHere = flitSendVld && (flitSendVc == VcIdxW'(v));
      always_ff @(posedge clk) begin
        if (!rstN) shadowCnt <= CntW'(BufDepth);
        else shadowCnt <= shadowCnt + CntW'(dsFeedback[v]) - CntW'(sendHere);
      end
      // R5
      no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
        (dsFeedback[v] && !sendHere) |-> (shadowCnt < CntW'(BufDepth)));
      // R4
      no_empty_send_chk: assert property (@(posedge clk) disable iff (!rstN)
        sendHere |-> (shadowCnt != '0));
      // R4
      credit_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
        vcHasCredit[v] == (shadowCnt != '0));
    end
  end else begin : g_onoff
    for (genvar v = 0; v < NumVc; v++) begin : g_vc
      // R8
      stop_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
        vcHasCredit[v] != dsFeedback[v]);
    end
  end
endmodule

bind vc_credit_tracker vc_credit_tracker_chk #(
  .NumVc(NumVc), .BufDepth(BufDepth), .OnOffMode(OnOffMode), .VcIdxW(VcIdxW)
) u_chk (
  .clk(clk), .rstN(rstN), .headGrantVld(headGrantVld), .headGrantVc(headGrantVc),
  .flitSendVld(flitSendVld), .flitSendVc(flitSendVc), .flitSendTail(flitSendTail),
  .dsFeedback(dsFeedback), .vcFree(vcFree), .vcHasCredit(vcHasCredit),
  .vcSendReady(vcSendReady)
);

// File: tb/tb_vc_credit_tracker.sv
module tb_vc_credit_tracker;
  localparam int NV = 4;
  localparam int BD = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grantVld = 1'b0;
  logic [1:0] grantVc = '0;
  logic sendVld = 1'b0;
  logic [1:0] sendVc = '0;
  logic sendTail = 1'b0;
  logic [NV-1:0] creditRet = '0;
  logic [NV-1:0] stopLvl = '0;
  logic [NV-1:0] freeA, credA, readyA, freeB, credB, readyB;

  int nChecks = 0;
  int nFails = 0;
  int mBusy[NV];
  int mCnt[NV];

  always #10 clk = ~clk;

  vc_credit_tracker #(.NumVc(NV), .BufDepth(BD), .OnOffMode(1'b0)) dut (
    .clk(clk), .rstN(rstN), .headGrantVld(grantVld), .headGrantVc(grantVc),
    .flitSendVld(sendVld), .flitSendVc(sendVc), .flitSendTail(sendTail),
    .dsFeedback(creditRet), .vcFree(freeA), .vcHasCredit(credA), .vcSendReady(readyA));

  vc_credit_tracker #(.NumVc(NV), .BufDepth(BD), .OnOffMode(1'b1)) dutOo (
    .clk(clk), .rstN(rstN), .headGrantVld(grantVld), .headGrantVc(grantVc),
    .flitSendVld(sendVld), .flitSendVc(sendVc), .flitSendTail(sendTail),
    .dsFeedback(stopLvl), .vcFree(freeB), .vcHasCredit(credB), .vcSendReady(readyB));

  task automatic expect1(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Advance the reference one clock from current inputs, then compare all outputs
  task automatic tick();
    for (int v = 0; v < NV; v++) begin
      if (!rstN) begin
        mBusy[v] = 0;
        mCnt[v] = BD;
      end else begin
        if (grantVld && grantVc == 2'(v)) mBusy[v] = 1;
        else if (sendVld && sendVc == 2'(v) && sendTail) mBusy[v] = 0;
        mCnt[v] = mCnt[v] + int'(creditRet[v]) - ((sendVld && sendVc == 2'(v)) ? 1 : 0);
      end
    end
    @(posedge clk);
    #2;
    for (int v = 0; v < NV; v++) begin
      expect1("R1 R2 R3 R9 free (credit)", freeA[v], mBusy[v] == 0);
      expect1("R4 R5 R6 R9 credit flag", credA[v], mCnt[v] > 0);
      expect1("R7 ready (credit)", readyA[v], mBusy[v] != 0 && mCnt[v] > 0);
      expect1("R2 R3 free (on/off)", freeB[v], mBusy[v] == 0);
      expect1("R8 credit flag (on/off)", credB[v], !stopLvl[v]);
      expect1("R7 ready (on/off)", readyB[v], mBusy[v] != 0 && !stopLvl[v]);
    end
  endtask

  task automatic idle();
    grantVld = 0; sendVld = 0; sendTail = 0; creditRet = '0;
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    idle();
    tick(); tick();
    rstN = 1;
    tick();
    // R1: reset state
    expect1("R1 all free", &freeA, 1'b1);
    expect1("R1 all credit", &credA, 1'b1);

    // R2: claim VC0
    grantVld = 1; grantVc = 0; tick(); idle();
    expect1("R2 VC0 owned", freeA[0], 1'b0);
    // R4: drain VC0 with body flits
    for (int i = 0; i < BD; i++) begin
      sendVld = 1; sendVc = 0; sendTail = 0; tick();
    end
    idle(); tick();
    expect1("R4 VC0 empty", credA[0], 1'b0);
    expect1("R7 VC0 not ready", readyA[0], 1'b0);
    expect1("R3 VC0 still owned", freeA[0], 1'b0);
    expect1("R9 VC1 untouched", credA[1], 1'b1);
    // R5: one credit back
    creditRet[0] = 1; tick(); idle();
    expect1("R5 VC0 credit back", credA[0], 1'b1);
    // R6: send and return together, count stays at one
    sendVld = 1; sendVc = 0; creditRet[0] = 1; tick(); idle();
    expect1("R6 VC0 still has one", credA[0], 1'b1);
    // R3: tail leaves
    sendVld = 1; sendVc = 0; sendTail = 1; tick(); idle();
    expect1("R3 VC0 freed", freeA[0], 1'b1);
    expect1("R4 VC0 empty again", credA[0], 1'b0);
    for (int i = 0; i < BD; i++) begin
      creditRet[0] = 1; tick();
    end
    idle();
    // R8: stop level in on/off mode
    grantVld = 1; grantVc = 2; tick(); idle();
    stopLvl[2] = 1; tick();
    expect1("R8 on/off stop", credB[2], 1'b0);
    expect1("R8 counting ignores level", credA[2], 1'b1);
    stopLvl[2] = 0; tick();
    expect1("R8 on/off resume", readyB[2], 1'b1);

    // Random legal traffic
    for (int n = 0; n < 3000; n++) begin
      int gv, sv;
      idle();
      stopLvl = NV'($urandom);
      gv = $urandom_range(NV - 1);
      if (mBusy[gv] == 0 && $urandom_range(1) == 1) begin
        grantVld = 1; grantVc = 2'(gv);
      end
      sv = $urandom_range(NV - 1);
      if (mBusy[sv] != 0 && mCnt[sv] > 0 && !stopLvl[sv] && $urandom_range(3) != 0) begin
        sendVld = 1; sendVc = 2'(sv); sendTail = ($urandom_range(2) == 0);
      end
      for (int v = 0; v < NV; v++)
        if (mCnt[v] < BD && $urandom_range(2) == 0) creditRet[v] = 1;
      tick();
    end
    idle();
    tick();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule